// File: doc/BRIEF.md
# Mode-Scaled LCD Sync Timing Generator

This block produces the line sync, frame sync and data-valid window for a 320x240 panel driven over a parallel pixel interface. Every count is in interface clock ticks. A 2-bit mode input selects how many ticks one pixel takes. The mode also sets a small latency correction that moves the start of the data-valid window, so that it makes up for a packing pipeline further down the path. Both syncs are active low.

A frame holds the 240 visible lines plus 4 blanking lines. Two blanking lines sit above the visible area and two sit below it. The generator also brings out its line counter and its tick-within-line counter, so a pixel source can address its data. A mode change on the input is taken up only when a frame completes. Dropping the enable input stops the generator, clears both counters and forces the outputs idle. Raising it again starts a fresh frame from line 0, tick 0.

Top module: `lcdt_sync_gen`

## Requirements
- R1: The mode input selects the ticks per pixel (cpp) and the latency correction (corr). Code 0 gives cpp 1 and corr 0 (16-bit 565). Code 1 gives cpp 2 and corr 3 (8-bit 565). Code 2 gives cpp 3 and corr 5 (8-bit 888). The spare code 3 behaves exactly like code 0.
- R2: Each line lasts 336*cpp ticks. Within a line, the tick counter output counts up by one per clock from 0.
- R3: hsync_n is low for the first 2*cpp ticks of every line and high for the rest of the line.
- R4: In a visible line, de is high for 320*cpp consecutive ticks, starting at tick 7*cpp+corr. de is never high while hsync_n is low.
- R5: A frame is 244 lines. The line output reads 0 to 243, reads 0 to 243 in order at the first tick of each line, and changes only where the tick counter is 0.
- R6: vsync_n goes low only on line 0. It goes low on the same tick as hsync_n and stays low for 2*cpp ticks.
- R7: de is high only on lines 2 to 241. Lines 0, 1, 242 and 243 carry no de at all.
- R8: A mode change on the input during a frame has no effect on that frame. The new mode governs from line 0 of the next frame.
- R9: While en is low, both counters read 0, both syncs are high and de is low. In the first cycle after en is sampled high, line 0 tick 0 is presented.
- R10: After a synchronous reset, hsync_n and vsync_n are high, de is low, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| mode | input | 2 | Pixel transfer mode code (R1) |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| de | output | 1 | Data-valid window |
| line | output | 8 | Current line number, 0 to 243 |
| htick | output | 10 | Tick within the current line |

## Verification
The frame boundary is where two functions meet in a single cycle. On that tick, the line counter wraps from 243 to 0 and the new mode is latched. The bench provokes this by changing the mode input a few hundred ticks into a frame in the 16-bit mode. The last line of that frame must still measure 336 ticks. The first line after the wrap must already measure the new 1008-tick period and carry a 6-tick frame sync aligned with the line sync. Every line is measured from one falling line-sync edge to the next and compared against a record computed from the requirement formulas.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int MAX_CPP = 3;

    typedef enum logic [1:0] {
        MODE_W16_565 = 2'd0,
        MODE_N8_565  = 2'd1,
        MODE_N8_888  = 2'd2,
        MODE_SPARE   = 2'd3
    } lcd_mode_e;

    typedef struct packed {
        int cpp;
        int corr;
    } mode_scale_t;

    typedef struct packed {
        int last;      // final tick index of a line
        int pulse;     // line sync width
        int de_first;  // first data-valid tick
        int de_end;    // first tick past the window
        int v_pulse;   // frame sync width
    } line_timing_t;

    // R1: mode code to scale factor and pipeline correction
    function automatic mode_scale_t mode_scale(lcd_mode_e m);
        mode_scale_t s;
        case (m)
            MODE_N8_565: begin s.cpp = 2; s.corr = 3; end
            MODE_N8_888: begin s.cpp = 3; s.corr = 5; end
            default:     begin s.cpp = 1; s.corr = 0; end
        endcase
        return s;
    endfunction

    function automatic line_timing_t line_timing(mode_scale_t s, int total, int act,
                                                 int sync, int lead, int vsync);
        line_timing_t t;
        t.last     = total * s.cpp - 1;
        t.pulse    = sync * s.cpp;
        t.de_first = lead * s.cpp + s.corr;
        t.de_end   = lead * s.cpp + s.corr + act * s.cpp;
        t.v_pulse  = vsync * s.cpp;
        return t;
    endfunction

endpackage

// File: rtl/lcdt_mode_reg.sv
module lcdt_mode_reg
    import lcdt_pkg::*;
#(
    parameter int TICK_W  = 10,
    parameter int H_TOTAL = 336,
    parameter int H_ACT   = 320,
    parameter int H_SYNC  = 2,
    parameter int H_LEAD  = 7,
    parameter int V_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  lcd_mode_e         mode_in,
    output logic [TICK_W-1:0] h_last,
    output logic [TICK_W-1:0] h_pulse,
    output logic [TICK_W-1:0] de_first,
    output logic [TICK_W-1:0] de_end,
    output logic [TICK_W-1:0] v_pulse
);
    lcd_mode_e    cur_mode;
    line_timing_t tim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= MODE_W16_565;
        end else if (load) begin
            cur_mode <= mode_in;
        end
    end

    always_comb begin
        tim      = line_timing(mode_scale(cur_mode), H_TOTAL, H_ACT, H_SYNC, H_LEAD, V_SYNC);
        h_last   = TICK_W'(tim.last);
        h_pulse  = TICK_W'(tim.pulse);
        de_first = TICK_W'(tim.de_first);
        de_end   = TICK_W'(tim.de_end);
        v_pulse  = TICK_W'(tim.v_pulse);
    end
endmodule

// File: rtl/lcdt_counters.sv
module lcdt_counters #(
    parameter int TICK_W  = 10,
    parameter int LINE_W  = 8,
    parameter int V_TOTAL = 244
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [TICK_W-1:0] h_last,
    output logic              run,
    output logic              frame_end,
    output logic [TICK_W-1:0] htick,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_TOTAL - 1);

    logic line_end;

    assign line_end  = run && (htick == h_last);
    assign frame_end = line_end && (line == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run   <= 1'b0;
            htick <= '0;
            line  <= '0;
        end else begin
            run <= 1'b1;
            if (line_end) begin
                htick <= '0;
                line  <= (line == LINE_LAST) ? '0 : line + 1'b1;
            end else if (run) begin
                htick <= htick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcdt_decode.sv
module lcdt_decode #(
    parameter int TICK_W = 10,
    parameter int LINE_W = 8,
    parameter int V_LEAD = 2,
    parameter int V_VIS  = 240
) (
    input  logic              run,
    input  logic [TICK_W-1:0] htick,
    input  logic [LINE_W-1:0] line,
    input  logic [TICK_W-1:0] h_pulse,
    input  logic [TICK_W-1:0] de_first,
    input  logic [TICK_W-1:0] de_end,
    input  logic [TICK_W-1:0] v_pulse,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de
);
    localparam logic [LINE_W-1:0] VIS_FIRST = LINE_W'(V_LEAD);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(V_LEAD + V_VIS);

    logic vis_line;
    logic in_window;

    always_comb begin
        vis_line  = (line >= VIS_FIRST) && (line < VIS_END);
        in_window = (htick >= de_first) && (htick < de_end);
        hsync_n   = !(run && (htick < h_pulse));
        vsync_n   = !(run && (line == '0) && (htick < v_pulse));
        de        = run && vis_line && in_window;
    end
endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen
    import lcdt_pkg::*;
#(
    parameter int H_ACT   = 320,
    parameter int H_TOTAL = 336,
    parameter int H_SYNC  = 2,
    parameter int H_LEAD  = 7,
    parameter int V_VIS   = 240,
    parameter int V_BLANK = 4,
    parameter int V_SYNC  = 2,
    localparam int V_TOTAL = V_VIS + V_BLANK,
    localparam int V_LEAD  = V_BLANK / 2,
    localparam int TICK_W  = $clog2(H_TOTAL * MAX_CPP),
    localparam int LINE_W  = $clog2(V_TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        mode,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [LINE_W-1:0] line,
    output logic [TICK_W-1:0] htick
);
    logic              run;
    logic              frame_end;
    logic [TICK_W-1:0] h_last, h_pulse, de_first, de_end, v_pulse;

    lcdt_mode_reg #(
        .TICK_W(TICK_W), .H_TOTAL(H_TOTAL), .H_ACT(H_ACT),
        .H_SYNC(H_SYNC), .H_LEAD(H_LEAD), .V_SYNC(V_SYNC)
    ) u_mode (
        .clk(clk), .rst(rst),
        .load(!run || frame_end),
        .mode_in(lcd_mode_e'(mode)),
        .h_last(h_last), .h_pulse(h_pulse),
        .de_first(de_first), .de_end(de_end), .v_pulse(v_pulse)
    );

    lcdt_counters #(
        .TICK_W(TICK_W), .LINE_W(LINE_W), .V_TOTAL(V_TOTAL)
    ) u_cnt (
        .clk(clk), .rst(rst), .en(en), .h_last(h_last),
        .run(run), .frame_end(frame_end), .htick(htick), .line(line)
    );

    lcdt_decode #(
        .TICK_W(TICK_W), .LINE_W(LINE_W), .V_LEAD(V_LEAD), .V_VIS(V_VIS)
    ) u_dec (
        .run(run), .htick(htick), .line(line),
        .h_pulse(h_pulse), .de_first(de_first), .de_end(de_end), .v_pulse(v_pulse),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de)
    );
endmodule

// File: rtl/lcdt_sync_chk.sv
module lcdt_sync_chk #(
    parameter int TICK_W  = 10,
    parameter int LINE_W  = 8,
    parameter int V_TOTAL = 244
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              de,
    input logic [LINE_W-1:0] line,
    input logic [TICK_W-1:0] htick
);
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hsync_n && vsync_n && !de && line == '0 && htick == '0)); // R9

    AST_DE_CLEAR_OF_HSYNC: assert property (@(posedge clk) disable iff (rst)
        de |-> hsync_n); // R4

    AST_VSYNC_IN_HSYNC: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> (!hsync_n && line == '0)); // R6

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        line < LINE_W'(V_TOTAL)); // R5

    AST_LINE_HOLDS_MIDLINE: assert property (@(posedge clk) disable iff (rst)
        (htick != '0) |-> $stable(line)); // R5

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && htick != '0) |-> (htick == TICK_W'($past(htick) + 1'b1))); // R2
endmodule

bind lcdt_sync_gen lcdt_sync_chk #(
    .TICK_W(TICK_W), .LINE_W(LINE_W), .V_TOTAL(V_TOTAL)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .line(line), .htick(htick)
);

// File: tb/sim_lcdt_sync_gen.sv
`timescale 1ns/1ps
module sim_lcdt_sync_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       hsync_n, vsync_n, de;
    logic [7:0] line;
    logic [9:0] htick;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int period;
        int hw;
        int de_start;
        int de_len;
        int vs_len;
        int line_no;
    } line_rec_t;

    line_rec_t exp_q[$];

    always #5 clk = ~clk;

    lcdt_sync_gen u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode_sel),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .line(line), .htick(htick)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side: expected records from the requirement formulas (R1..R7)
    task automatic push_lines(int code, int first, int count);
        int cpp, corr;
        case (code)
            1: begin cpp = 2; corr = 3; end
            2: begin cpp = 3; corr = 5; end
            default: begin cpp = 1; corr = 0; end
        endcase
        for (int k = 0; k < count; k++) begin
            line_rec_t r;
            int ln = (first + k) % 244;
            r.period   = 336 * cpp;
            r.hw       = 2 * cpp;
            r.vs_len   = (ln == 0) ? 2 * cpp : 0;
            r.de_len   = (ln >= 2 && ln <= 241) ? 320 * cpp : 0;
            r.de_start = (r.de_len != 0) ? 7 * cpp + corr : -1;
            r.line_no  = ln;
            exp_q.push_back(r);
        end
    endtask

    // monitor: measures each line between falling line-sync edges
    int  pos, m_hw, m_de_start, m_de_len, m_vs, m_line, m_tick;
    bit  active  = 0;
    bit  prev_hs = 1;

    task automatic finish_line();
        line_rec_t e;
        if (exp_q.size() == 0) begin
            check("R5", "unexpected extra line", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        check("R2", "line period", pos, e.period);
        check("R3", "hsync low width", m_hw, e.hw);
        check("R6", "vsync low width", m_vs, e.vs_len);
        check("R7", "de tick count", m_de_len, e.de_len);
        check("R4", "de first tick", m_de_start, e.de_start);
        check("R5", "line number at line start", m_line, e.line_no);
        check("R2", "tick counter at line start", m_tick, 0);
    endtask

    always @(negedge clk) begin
        if (rst || !en) begin
            active  = 0;
            prev_hs = 1;
        end else begin
            if (prev_hs && !hsync_n) begin
                if (active) finish_line();
                active     = 1;
                pos        = 0;
                m_hw       = 0;
                m_vs       = 0;
                m_de_len   = 0;
                m_de_start = -1;
                m_line     = int'(line);
                m_tick     = int'(htick);
            end
            if (active) begin
                if (!hsync_n) m_hw++;
                if (!vsync_n) m_vs++;
                if (de) begin
                    if (m_de_start < 0) m_de_start = pos;
                    m_de_len++;
                end
                pos++;
            end
            prev_hs = hsync_n;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic check_idle(string req);
        check(req, "hsync_n idle", int'(hsync_n), 1);
        check(req, "vsync_n idle", int'(vsync_n), 1);
        check(req, "de idle", int'(de), 0);
        check(req, "line idle", int'(line), 0);
        check(req, "htick idle", int'(htick), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R10");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R9");

        // full frame in the 16-bit mode; a mid-frame change to the 888 mode
        // must wait for the frame boundary (R8, R1)
        mode_sel = 2'd0;
        push_lines(0, 0, 244);
        push_lines(2, 0, 3);
        en = 1'b1;
        repeat (200) @(negedge clk);
        mode_sel = 2'd2;
        drain();

        // stop mid-line: outputs must go idle (R9)
        en = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R9");

        // restart in the 8-bit 565 mode from line 0 (R9, R1)
        mode_sel = 2'd1;
        push_lines(1, 0, 3);
        en = 1'b1;
        drain();
        en = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R9");

        // spare code behaves like code 0 (R1)
        mode_sel = 2'd3;
        push_lines(3, 0, 3);
        en = 1'b1;
        drain();
        en = 1'b0;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion (%0d lines pending)", exp_q.size());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule